// File: doc/BRIEF.md
# Drive Geometry Binary Search Prober

The prober works out the head count, cylinder count and sectors-per-track count of a drive whose geometry is unknown. It does not read any geometry table. Instead it asks an external command sequencer to seek to trial head/cylinder/sector positions and watches whether each seek succeeds. For each dimension it keeps a lower bound (a value known to work) and an upper bound (a value known to fail or the search limit). It tests the midpoint and moves one of the two bounds onto it, until the two bounds are adjacent.

Heads are searched first, then cylinders, then sectors. While a dimension is being searched, dimensions already solved are probed at their found value and dimensions not yet reached are probed at zero. When all three are settled the block reports each count as the final lower bound plus one, with a one-cycle done pulse. It also reports a control byte of zero. A per-dimension probe budget raises a sticky error flag if one dimension needs more probes than allowed.

The seek itself is carried out outside the block through a request/response handshake. The block raises a request with a stable position tuple. The sequencer answers with a one-cycle acknowledge and a pass/fail bit.

Top module: `geometry_prober`

## Requirements
- R1: While reset is held and after it is released, probe_req, done and err are 0, and all three count outputs are 0.
- R2: start is accepted only while no search is running, and it begins a new search with every lower bound at 0 and the upper bounds at HEAD_LIMIT, CYL_LIMIT and SEC_LIMIT. A start pulse during a search has no effect on the probe sequence or on err.
- R3: Dimensions are searched in the order heads, cylinders, sectors. During a probe, a dimension not yet reached is presented as 0 and an already solved dimension is presented as its final lower bound.
- R4: The dimension under search is presented as (lower + upper) / 2, rounded down.
- R5: An acknowledge with probe_ok=1 moves the lower bound to the tested value, and one with probe_ok=0 moves the upper bound to it. A dimension is solved, and probes no further, when lower equals upper minus one.
- R6: probe_req stays high with an unchanged tuple until probe_ack is seen, and drops in the cycle after it. probe_ack while no request is up is ignored.
- R7: done is a one-cycle pulse after the last dimension is solved. head_count, cyl_count and sec_count then show each final lower bound plus one, and they hold until the next done.
- R8: ctrl_byte is always 0.
- R9: If a single dimension receives more than PROBE_LIMIT acknowledged probes, err goes to 1 in the cycle after that acknowledge. It stays at 1 until the next accepted start, and the search still runs to completion.
- R10: If every seek fails, all three counts come out as 1. If the drive is larger than the limits, the counts saturate at HEAD_LIMIT, CYL_LIMIT and SEC_LIMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a geometry search (ignored while busy) |
| probe_req | output | 1 | Seek request to the external sequencer |
| probe_head | output | $clog2(HEAD_LIMIT) | Head of the seek tuple |
| probe_cyl | output | $clog2(CYL_LIMIT) | Cylinder of the seek tuple |
| probe_sec | output | $clog2(SEC_LIMIT) | Sector of the seek tuple |
| probe_ack | input | 1 | One-cycle response to the current request |
| probe_ok | input | 1 | Seek result, valid with probe_ack (1 = success) |
| done | output | 1 | One-cycle pulse when all counts are valid |
| head_count | output | $clog2(HEAD_LIMIT+1) | Heads found |
| cyl_count | output | $clog2(CYL_LIMIT+1) | Cylinders found |
| sec_count | output | $clog2(SEC_LIMIT+1) | Sectors per track found |
| ctrl_byte | output | 8 | Reported control byte, always zero |
| err | output | 1 | Sticky probe-budget overrun flag |

## Verification
Two events can land in the same cycle. The first is a response that arrives in the very first cycle of a request. The bench answers some probes with zero wait, so the block must take the result, move a bound and drop the request at once. The second is a start pulse that arrives while probing is under way. The bench pulses start in the middle of a search, after the lowered probe budget has already set err. The sequence of seek tuples must still match the behavioural bisection exactly, and err must stay set. That shows the start was ignored and neither restarted the bounds nor cleared the flag.

// File: rtl/geo_probe_pkg.sv
package geo_probe_pkg;

   localparam int NUM_DIMS = 3;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_PICK,
      SQ_ASK,
      SQ_FIN
   } seq_state_t;

   typedef enum logic [1:0] {
      ROLE_PENDING,
      ROLE_ACTIVE,
      ROLE_SOLVED
   } dim_role_t;

   function automatic int count_width(input int upper);
      return $clog2(upper + 1);
   endfunction

endpackage

// File: rtl/geo_dim_bisect.sv
module geo_dim_bisect
   import geo_probe_pkg::*;
#(
   parameter int UPPER = 16,
   parameter int W     = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         update,
   input  logic         pass,
   input  dim_role_t    role,
   output logic [W-1:0] probe_val,
   output logic         settled,
   output logic [W-1:0] count
);

   localparam logic [W-1:0] TOP = W'(UPPER);

   if (UPPER < 2) begin : g_bad_upper
      $error("geo_dim_bisect: UPPER must be at least 2");
   end
   if (W < $clog2(UPPER + 1)) begin : g_bad_width
      $error("geo_dim_bisect: W too narrow for UPPER");
   end

   logic [W-1:0] lo_q, hi_q;
   logic [W:0]   bound_sum;
   logic [W-1:0] mid;

   assign bound_sum = {1'b0, lo_q} + {1'b0, hi_q};
   assign mid       = bound_sum[W:1];
   assign settled   = (({1'b0, lo_q} + (W+1)'(1)) == {1'b0, hi_q});
   assign count     = lo_q + W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= TOP;
      end else if (clear) begin
         lo_q <= '0;
         hi_q <= TOP;
      end else if (update) begin
         if (pass) lo_q <= mid;
         else      hi_q <= mid;
      end
   end

   always_comb begin
      case (role)
         ROLE_ACTIVE: probe_val = mid;
         ROLE_SOLVED: probe_val = lo_q;
         default:     probe_val = '0;
      endcase
   end

endmodule

// File: rtl/geo_probe_seq.sv
module geo_probe_seq
   import geo_probe_pkg::*;
#(
   parameter int NDIM = 3,
   parameter int DW   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            ack,
   input  logic [NDIM-1:0] settled,
   output logic            req,
   output logic            clear,
   output logic            update,
   output logic            advance,
   output logic            fin,
   output logic [DW-1:0]   cur_dim
);

   localparam int            PADN = 1 << DW;
   localparam logic [DW-1:0] LAST = DW'(NDIM - 1);

   if (PADN < NDIM) begin : g_bad_dw
      $error("geo_probe_seq: DW too narrow for NDIM");
   end

   seq_state_t        state_q;
   logic [DW-1:0]     dim_q;
   logic [PADN-1:0]   settled_pad;
   logic              cur_settled;

   assign settled_pad = PADN'(settled);
   assign cur_settled = settled_pad[dim_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         dim_q   <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               if (start) begin
                  state_q <= SQ_PICK;
                  dim_q   <= '0;
               end
            end
            SQ_PICK: begin
               if (cur_settled) begin
                  if (dim_q == LAST) state_q <= SQ_FIN;
                  else               dim_q   <= dim_q + DW'(1);
               end else begin
                  state_q <= SQ_ASK;
               end
            end
            SQ_ASK: begin
               if (ack) state_q <= SQ_PICK;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign req     = (state_q == SQ_ASK);
   assign clear   = (state_q == SQ_IDLE) && start;
   assign update  = req && ack;
   assign advance = (state_q == SQ_PICK) && cur_settled && (dim_q != LAST);
   assign fin     = (state_q == SQ_FIN);
   assign cur_dim = dim_q;

endmodule

// File: rtl/geo_probe_budget.sv
module geo_probe_budget #(
   parameter int LIMIT = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic restart,
   input  logic tick,
   output logic err
);

   localparam int            CW  = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] CAP = CW'(LIMIT);

   if (LIMIT < 1) begin : g_bad_limit
      $error("geo_probe_budget: LIMIT must be at least 1");
   end

   logic [CW-1:0] used_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         used_q <= '0;
         err    <= 1'b0;
      end else if (clear) begin
         used_q <= '0;
         err    <= 1'b0;
      end else if (restart) begin
         used_q <= '0;
      end else if (tick) begin
         if (used_q == CAP) err <= 1'b1;
         else               used_q <= used_q + CW'(1);
      end
   end

endmodule

// File: rtl/geo_result_reg.sv
module geo_result_reg #(
   parameter int N = 3,
   parameter int W = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [N-1:0][W-1:0] din,
   output logic [N-1:0][W-1:0] dout,
   output logic                valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= load;
         if (load) dout <= din;
      end
   end

endmodule

// File: rtl/geometry_prober.sv
module geometry_prober
   import geo_probe_pkg::*;
#(
   parameter int HEAD_LIMIT  = 16,
   parameter int CYL_LIMIT   = 1024,
   parameter int SEC_LIMIT   = 64,
   parameter int PROBE_LIMIT = 11,
   parameter bit BUDGET_EN   = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             start,
   output logic                             probe_req,
   output logic [$clog2(HEAD_LIMIT)-1:0]    probe_head,
   output logic [$clog2(CYL_LIMIT)-1:0]     probe_cyl,
   output logic [$clog2(SEC_LIMIT)-1:0]     probe_sec,
   input  logic                             probe_ack,
   input  logic                             probe_ok,
   output logic                             done,
   output logic [$clog2(HEAD_LIMIT+1)-1:0]  head_count,
   output logic [$clog2(CYL_LIMIT+1)-1:0]   cyl_count,
   output logic [$clog2(SEC_LIMIT+1)-1:0]   sec_count,
   output logic [7:0]                       ctrl_byte,
   output logic                             err
);

   localparam int HP_W = $clog2(HEAD_LIMIT);
   localparam int CP_W = $clog2(CYL_LIMIT);
   localparam int SP_W = $clog2(SEC_LIMIT);
   localparam int HC_W = count_width(HEAD_LIMIT);
   localparam int CC_W = count_width(CYL_LIMIT);
   localparam int SC_W = count_width(SEC_LIMIT);
   localparam int IW01 = (HC_W > CC_W) ? HC_W : CC_W;
   localparam int IW   = (IW01 > SC_W) ? IW01 : SC_W;
   localparam int DW   = $clog2(NUM_DIMS);

   if (HEAD_LIMIT < 2 || CYL_LIMIT < 2 || SEC_LIMIT < 2) begin : g_bad_limits
      $error("geometry_prober: every dimension limit must be at least 2");
   end

   logic                          seq_clear, seq_update, seq_advance, seq_fin;
   logic [DW-1:0]                 cur_dim;
   logic [NUM_DIMS-1:0]           settled;
   logic [NUM_DIMS-1:0][IW-1:0]   probe_vals;
   logic [NUM_DIMS-1:0][IW-1:0]   found;
   logic [NUM_DIMS-1:0][IW-1:0]   result;

   geo_probe_seq #(
      .NDIM (NUM_DIMS),
      .DW   (DW)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .ack     (probe_ack),
      .settled (settled),
      .req     (probe_req),
      .clear   (seq_clear),
      .update  (seq_update),
      .advance (seq_advance),
      .fin     (seq_fin),
      .cur_dim (cur_dim)
   );

   for (genvar g = 0; g < NUM_DIMS; g++) begin : g_dim
      localparam int UP = (g == 0) ? HEAD_LIMIT : (g == 1) ? CYL_LIMIT : SEC_LIMIT;
      dim_role_t role;
      logic      upd_here;

      assign role = (DW'(g) < cur_dim)  ? ROLE_SOLVED :
                    (DW'(g) == cur_dim) ? ROLE_ACTIVE : ROLE_PENDING;
      assign upd_here = seq_update && (cur_dim == DW'(g));

      geo_dim_bisect #(
         .UPPER (UP),
         .W     (IW)
      ) u_bisect (
         .clk       (clk),
         .rst_n     (rst_n),
         .clear     (seq_clear),
         .update    (upd_here),
         .pass      (probe_ok),
         .role      (role),
         .probe_val (probe_vals[g]),
         .settled   (settled[g]),
         .count     (found[g])
      );
   end

   if (BUDGET_EN) begin : g_budget
      geo_probe_budget #(
         .LIMIT (PROBE_LIMIT)
      ) u_budget (
         .clk     (clk),
         .rst_n   (rst_n),
         .clear   (seq_clear),
         .restart (seq_advance),
         .tick    (seq_update),
         .err     (err)
      );
   end else begin : g_no_budget
      assign err = 1'b0;
   end

   geo_result_reg #(
      .N (NUM_DIMS),
      .W (IW)
   ) u_result (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (seq_fin),
      .din   (found),
      .dout  (result),
      .valid (done)
   );

   assign probe_head = probe_vals[0][HP_W-1:0];
   assign probe_cyl  = probe_vals[1][CP_W-1:0];
   assign probe_sec  = probe_vals[2][SP_W-1:0];
   assign head_count = result[0][HC_W-1:0];
   assign cyl_count  = result[1][CC_W-1:0];
   assign sec_count  = result[2][SC_W-1:0];
   assign ctrl_byte  = 8'h00;

endmodule

// File: rtl/geometry_prober_chk.sv
module geometry_prober_chk #(
   parameter int HEAD_LIMIT = 16,
   parameter int CYL_LIMIT  = 1024,
   parameter int SEC_LIMIT  = 64
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            start,
   input logic                            probe_req,
   input logic [$clog2(HEAD_LIMIT)-1:0]   probe_head,
   input logic [$clog2(CYL_LIMIT)-1:0]    probe_cyl,
   input logic [$clog2(SEC_LIMIT)-1:0]    probe_sec,
   input logic                            probe_ack,
   input logic                            done,
   input logic [$clog2(HEAD_LIMIT+1)-1:0] head_count,
   input logic [$clog2(CYL_LIMIT+1)-1:0]  cyl_count,
   input logic [$clog2(SEC_LIMIT+1)-1:0]  sec_count,
   input logic                            err
);

   // R6: request is held while unanswered
   assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      probe_req && !probe_ack |=> probe_req);

   // R6: tuple does not move while waiting
   assert_tuple_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      probe_req && !probe_ack |=> $stable({probe_head, probe_cyl, probe_sec}));

   // R6: request drops after it is answered
   assert_req_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      probe_req && probe_ack |=> !probe_req);

   // R7: done lasts one cycle
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: no request outstanding when results are announced
   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !probe_req);

   // R7: counts only change when done is shown
   assert_counts_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable({head_count, cyl_count, sec_count}));

   // R10: reported counts lie between one and the limits
   assert_count_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (head_count >= 1 && int'(head_count) <= HEAD_LIMIT &&
                cyl_count  >= 1 && int'(cyl_count)  <= CYL_LIMIT  &&
                sec_count  >= 1 && int'(sec_count)  <= SEC_LIMIT));

   // R9: error flag is sticky until a new start
   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err && !start |=> err);

endmodule

bind geometry_prober geometry_prober_chk #(
   .HEAD_LIMIT (HEAD_LIMIT),
   .CYL_LIMIT  (CYL_LIMIT),
   .SEC_LIMIT  (SEC_LIMIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .probe_req  (probe_req),
   .probe_head (probe_head),
   .probe_cyl  (probe_cyl),
   .probe_sec  (probe_sec),
   .probe_ack  (probe_ack),
   .done       (done),
   .head_count (head_count),
   .cyl_count  (cyl_count),
   .sec_count  (sec_count),
   .err        (err)
);

// File: tb/geometry_prober_bench.sv
module geometry_prober_bench;

   localparam int HL = 16;
   localparam int CL = 1024;
   localparam int SL = 64;
   localparam int PL = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic ack = 1'b0;
   logic ok = 1'b0;

   logic                      probe_req;
   logic [$clog2(HL)-1:0]     probe_head;
   logic [$clog2(CL)-1:0]     probe_cyl;
   logic [$clog2(SL)-1:0]     probe_sec;
   logic                      done;
   logic [$clog2(HL+1)-1:0]   head_count;
   logic [$clog2(CL+1)-1:0]   cyl_count;
   logic [$clog2(SL+1)-1:0]   sec_count;
   logic [7:0]                ctrl_byte;
   logic                      err;

   geometry_prober #(
      .HEAD_LIMIT  (HL),
      .CYL_LIMIT   (CL),
      .SEC_LIMIT   (SL),
      .PROBE_LIMIT (PL)
   ) u_geometry_prober (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .probe_req  (probe_req),
      .probe_head (probe_head),
      .probe_cyl  (probe_cyl),
      .probe_sec  (probe_sec),
      .probe_ack  (ack),
      .probe_ok   (ok),
      .done       (done),
      .head_count (head_count),
      .cyl_count  (cyl_count),
      .sec_count  (sec_count),
      .ctrl_byte  (ctrl_byte),
      .err        (err)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;

   // reference model state
   int  qh[$], qc[$], qs[$], qok[$], qover[$];
   int  exp_h, exp_c, exp_s;
   int  lat_seed = 0;
   int  wait_cnt = 0;
   bit  pending = 0, cur_ok = 0, cur_over = 0;
   bit  exp_err = 0, running = 0;
   bit  stray_req = 0, stray_on = 0;
   bit  after_done = 0;
   int  held_h, held_c, held_s;

   task automatic check(input bit cond, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // behavioural bisection: fills the expected probe queues and results
   task automatic plan(input int h, input int c, input int s);
      int lo[3], hi[3], t[3], n;
      int lim[3];
      lim[0] = HL; lim[1] = CL; lim[2] = SL;
      qh.delete(); qc.delete(); qs.delete(); qok.delete(); qover.delete();
      for (int d = 0; d < 3; d++) begin
         lo[d] = 0; hi[d] = lim[d]; t[d] = 0;
      end
      for (int d = 0; d < 3; d++) begin
         n = 0;
         while (lo[d] != hi[d] - 1) begin
            int pass;
            t[d] = (lo[d] + hi[d]) / 2;
            pass = (t[0] < h && t[1] < c && t[2] < s) ? 1 : 0;
            n++;
            qh.push_back(t[0]); qc.push_back(t[1]); qs.push_back(t[2]);
            qok.push_back(pass);
            qover.push_back(n > PL ? 1 : 0);
            if (pass != 0) lo[d] = t[d];
            else           hi[d] = t[d];
         end
         t[d] = lo[d];
      end
      exp_h = lo[0] + 1; exp_c = lo[1] + 1; exp_s = lo[2] + 1;
   endtask

   function automatic int next_lat();
      if (lat_seed < 0) return 3;
      return (lat_seed * 5 + qh.size()) % 4;
   endfunction

   // responder and per-clock comparison
   always @(negedge clk) begin
      if (rst_n) begin
         if (ack) begin
            ack = 1'b0;
            if (stray_on) stray_on = 0;
            else begin
               pending = 0;
               if (cur_over) exp_err = 1;
            end
         end
         check(err == exp_err, "R9", "err flag", err, exp_err);
         check(ctrl_byte == 8'h00, "R8", "control byte", ctrl_byte, 0);
         if (after_done) begin
            after_done = 0;
            check(done == 1'b0, "R7", "done width", done, 0);
            check(head_count == held_h && cyl_count == held_c && sec_count == held_s,
                  "R7", "counts held", head_count, held_h);
         end
         if (probe_req && !pending) begin
            if (qh.size() == 0) begin
               check(0, "R3", "unexpected request", 1, 0);
            end else begin
               check(probe_head == qh[0], "R3", "probe head", probe_head, qh[0]);
               check(probe_cyl  == qc[0], "R4", "probe cylinder", probe_cyl, qc[0]);
               check(probe_sec  == qs[0], "R5", "probe sector", probe_sec, qs[0]);
               cur_ok   = (qok[0] != 0);
               cur_over = (qover[0] != 0);
               void'(qh.pop_front()); void'(qc.pop_front()); void'(qs.pop_front());
               void'(qok.pop_front()); void'(qover.pop_front());
               pending  = 1;
               wait_cnt = next_lat();
            end
         end else if (!probe_req && pending) begin
            check(0, "R6", "request dropped before answer", 0, 1);
            pending = 0;
         end
         if (pending && !ack) begin
            if (wait_cnt == 0) begin
               ack = 1'b1;
               ok  = cur_ok;
            end else begin
               wait_cnt--;
            end
         end else if (stray_req && !pending && !probe_req) begin
            stray_req = 0;
            stray_on  = 1;
            ack = 1'b1;
            ok  = 1'b1;
         end
         if (done) begin
            if (!running) begin
               check(0, "R7", "done without search", 1, 0);
            end else begin
               check(qh.size() == 0 && !pending, "R5", "probes left at done", qh.size(), 0);
               check(head_count == exp_h, "R7", "head count", head_count, exp_h);
               check(cyl_count  == exp_c, "R7", "cylinder count", cyl_count, exp_c);
               check(sec_count  == exp_s, "R10", "sector count", sec_count, exp_s);
               running = 0;
            end
            after_done = 1;
            held_h = head_count; held_c = cyl_count; held_s = sec_count;
         end
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic run(input int h, input int c, input int s, input int seed,
                      input bit poke);
      int n;
      plan(h, c, s);
      lat_seed = seed;
      @(posedge clk); #2 start = 1'b1;
      @(posedge clk); #2 start = 1'b0;
      exp_err = 0;
      running = 1;
      if (poke) begin
         // R2: start during a running search must not restart it or clear err
         repeat (78) @(posedge clk);
         #2 start = 1'b1;
         @(posedge clk); #2 start = 1'b0;
      end
      n = 0;
      while (running && n < 5000) begin
         @(posedge clk);
         n++;
      end
      if (running) begin
         check(0, "R7", "done never seen", 0, 1);
         running = 0;
      end
      repeat (3) @(posedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      check(probe_req == 1'b0, "R1", "request after reset", probe_req, 0);
      check(done == 1'b0, "R1", "done after reset", done, 0);
      check(err == 1'b0, "R1", "err after reset", err, 0);
      check(head_count == 0 && cyl_count == 0 && sec_count == 0, "R1",
            "counts after reset", head_count + cyl_count + sec_count, 0);
      run(4, 615, 17, 0, 1'b0);
      run(16, 1024, 64, -1, 1'b1);
      // R6: a stray acknowledge while idle must not disturb anything
      @(posedge clk); #2 stray_req = 1;
      repeat (4) @(posedge clk);
      run(0, 5, 5, 1, 1'b0);        // R10: every seek fails
      run(20, 2000, 100, 2, 1'b0);  // R10: saturation at the limits
      run(1, 1, 1, 3, 1'b0);
      run(9, 300, 33, 3, 1'b0);
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R7 watchdog: actual 0 expected 1");
      finish_run();
   end

endmodule